// File: doc/BRIEF.md
# Banked ROM Window Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a 512KiB ROM. It drives the ROM's upper address lines, A18 down to A11. The CPU's own address bits A10..A0 go straight to the ROM and give the byte inside a 2KiB page.

The lower half of the CPU space, $0000-$7FFF, reaches the first 32KiB of the ROM without translation. Above it there are four switchable windows:

| Window | CPU range | Size | Bank register width |
|---|---|---|---|
| 3 | $8000-$BFFF | 16KiB | 5 bits |
| 2 | $C000-$DFFF | 8KiB | 6 bits |
| 1 | $E000-$EFFF | 4KiB | 7 bits |
| 0 | $F000-$F7FF | 2KiB | 8 bits |

Each window has its own bank register, and the register's width sets that window's page granularity. Addresses $F800-$FFFF belong to no window.

A bank register is loaded without a data bus. A port strobe, decoded outside the block, captures a value on its rising edge. The value comes from CPU address bits 15:8, and address bits 1:0 pick the window. The port numbers $08 to $0B therefore load windows 0 to 3. While the strobe is low, the ROM address outputs are disabled.

Top module: `rom_window_mapper`

## Requirements
- R1: After reset every bank register holds zero, so each window's first byte reads ROM page 0 plus the window's page offset.
- R2: A register is written only in the clock cycle where port_strobe is sampled high after having been sampled low in the cycle before. The value is cpu_addr[15:8] and the target window is cpu_addr[1:0]. Holding the strobe high, or letting it fall, writes nothing.
- R3: A strobe that is already high when reset is released causes no write.
- R4: rom_oe is 0 whenever port_strobe is 0.
- R5: For cpu_addr below $8000, rom_addr equals cpu_addr[15:11], zero-extended to 8 bits. rom_oe equals port_strobe.
- R6: In window 3 ($8000-$BFFF), rom_addr[7:3] is the low 5 bits of the bank value and rom_addr[2:0] is cpu_addr[13:11]. Writing $81 with select 3 makes $8000-$BFFF read ROM $04000-$07FFF.
- R7: In window 2 ($C000-$DFFF), rom_addr[7:2] is the low 6 bits of the bank value and rom_addr[1:0] is cpu_addr[12:11].
- R8: In window 1 ($E000-$EFFF), rom_addr[7:1] is the low 7 bits of the bank value and rom_addr[0] is cpu_addr[11].
- R9: In window 0 ($F000-$F7FF), rom_addr is the full 8-bit bank value.
- R10: For cpu_addr in $F800-$FFFF, rom_addr is 0 and rom_oe is 0.
- R11: A write to one window leaves the other three bank registers unchanged.
- R12: Bank value bits above a window's register width are dropped. For example, $E1 written to window 3 acts as bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus; carries the bank value and window select during a port write |
| port_strobe | input | 1 | Externally decoded port write strobe; a rising edge loads a register |
| rom_addr | output | 8 | ROM address lines A18..A11 |
| rom_oe | output | 1 | Enable for the ROM address lines; low means high impedance |

## Verification
The hardest case to reach from the ports is a strobe edge that must not write. This covers a strobe held high across reset release, a strobe that stays high while the address changes, and a strobe that falls with a write pattern on the bus.

Every rising strobe edge loads some register, so reading the effect back always needs a fresh, deliberate write. The stimulus handles this by parking the strobe low with a decoy pattern on the bus. It then swaps in a known write to another window before raising the strobe, and checks that the untouched window still reads its old bank.

A full sweep of all 256 values into each window, with reads at every page boundary, covers the truncation and composition rules.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

   // Width of the bank register for window w: a larger window needs fewer bank bits.
   function automatic int unsigned win_reg_width(int unsigned out_w, int unsigned w);
      return out_w - w;
   endfunction

   // First 2KiB page of window w inside the CPU space: windows grow downward from the top.
   function automatic int unsigned win_base_page(int unsigned pg_w, int unsigned w);
      return (1 << pg_w) - (1 << (w + 1));
   endfunction

   // Number of pages in the straight-through region below the lowest window.
   function automatic int unsigned fixed_page_limit(int unsigned pg_w, int unsigned num_win);
      return (1 << pg_w) - (1 << num_win);
   endfunction

endpackage

// File: rtl/rwm_bank_file.sv
module rwm_bank_file #(
   parameter int unsigned OUT_W   = 8,
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned SEL_W   = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           strobe,
   input  logic [SEL_W-1:0]               sel,
   input  logic [OUT_W-1:0]               wdata,
   output logic [NUM_WIN-1:0][OUT_W-1:0]  bank_q
);

   logic strobe_d;
   logic rise;

   // Reset to 1 so a strobe already high at reset release is not seen as an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_d <= 1'b1;
      else        strobe_d <= strobe;
   end

   assign rise = strobe & ~strobe_d;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_reg
      localparam int unsigned RW = rwm_pkg::win_reg_width(OUT_W, w);
      logic [RW-1:0] r_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= '0;
         else if (rise && (sel == SEL_W'(w)))
            r_q <= wdata[RW-1:0];
      end

      assign bank_q[w] = OUT_W'(r_q);
   end

endmodule

// File: rtl/rwm_window_decode.sv
module rwm_window_decode #(
   parameter int unsigned PG_W    = 5,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic [PG_W-1:0]    page,
   output logic [NUM_WIN-1:0] win_hit,
   output logic               fixed_hit
);

   localparam logic [PG_W-1:0] FIX_LIM = PG_W'(rwm_pkg::fixed_page_limit(PG_W, NUM_WIN));

   assign fixed_hit = page < FIX_LIM;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
      localparam int unsigned BASE = rwm_pkg::win_base_page(PG_W, w);
      localparam logic [PG_W-1:0] FIRST_PG = PG_W'(BASE);
      localparam logic [PG_W-1:0] LAST_PG  = PG_W'(BASE + (1 << w) - 1);

      assign win_hit[w] = (page >= FIRST_PG) && (page <= LAST_PG);
   end

endmodule

// File: rtl/rwm_addr_compose.sv
module rwm_addr_compose #(
   parameter int unsigned PG_W    = 5,
   parameter int unsigned OUT_W   = 8,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic [PG_W-1:0]                page,
   input  logic [NUM_WIN-1:0][OUT_W-1:0]  bank_q,
   input  logic [NUM_WIN-1:0]             win_hit,
   input  logic                           fixed_hit,
   output logic [OUT_W-1:0]               rom_page
);

   logic [NUM_WIN-1:0][OUT_W-1:0] win_page;
   logic [OUT_W-1:0]              page_ext;

   assign page_ext = OUT_W'(page);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      // Bank bits sit above the w CPU page bits that select within the window.
      localparam logic [OUT_W-1:0] LOW_MASK = OUT_W'((1 << w) - 1);
      assign win_page[w] = (bank_q[w] << w) | (page_ext & LOW_MASK);
   end

   always_comb begin
      rom_page = '0;
      if (fixed_hit) rom_page = page_ext;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (win_hit[w]) rom_page = rom_page | win_page[w];
      end
   end

endmodule

// File: rtl/rom_window_mapper.sv
module rom_window_mapper #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned ROM_AW     = 19,
   parameter int unsigned PAGE_SHIFT = 11,
   parameter int unsigned NUM_WIN    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            cpu_addr,
   input  logic                         port_strobe,
   output logic [ROM_AW-PAGE_SHIFT-1:0] rom_addr,
   output logic                         rom_oe
);

   localparam int unsigned OUT_W = ROM_AW - PAGE_SHIFT;
   localparam int unsigned PG_W  = ADDR_W - PAGE_SHIFT;
   localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (NUM_WIN < 2)                  begin : g_chk_win  $error("NUM_WIN must be at least 2");               end
   if (PAGE_SHIFT + NUM_WIN > ADDR_W) begin : g_chk_span $error("windows do not fit the CPU space");        end
   if (ROM_AW < ADDR_W)              begin : g_chk_rom  $error("ROM must cover the fixed region");          end
   if (OUT_W < NUM_WIN)              begin : g_chk_out  $error("bank registers would have no bits");        end
   if (SEL_W + OUT_W > ADDR_W)       begin : g_chk_sel  $error("select and data fields overlap");           end

   logic [PG_W-1:0]               page;
   logic [OUT_W-1:0]              wdata;
   logic [SEL_W-1:0]              sel;
   logic [NUM_WIN-1:0][OUT_W-1:0] bank_q;
   logic [NUM_WIN-1:0]            win_hit;
   logic                          fixed_hit;
   logic                          unused_addr_bits;

   assign page             = cpu_addr[ADDR_W-1:PAGE_SHIFT];
   assign wdata            = cpu_addr[ADDR_W-1 -: OUT_W];
   assign sel              = cpu_addr[SEL_W-1:0];
   assign unused_addr_bits = ^cpu_addr;

   rwm_bank_file #(
      .OUT_W   (OUT_W),
      .NUM_WIN (NUM_WIN),
      .SEL_W   (SEL_W)
   ) u_banks (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (port_strobe),
      .sel    (sel),
      .wdata  (wdata),
      .bank_q (bank_q)
   );

   rwm_window_decode #(
      .PG_W    (PG_W),
      .NUM_WIN (NUM_WIN)
   ) u_decode (
      .page      (page),
      .win_hit   (win_hit),
      .fixed_hit (fixed_hit)
   );

   rwm_addr_compose #(
      .PG_W    (PG_W),
      .OUT_W   (OUT_W),
      .NUM_WIN (NUM_WIN)
   ) u_compose (
      .page      (page),
      .bank_q    (bank_q),
      .win_hit   (win_hit),
      .fixed_hit (fixed_hit),
      .rom_page  (rom_addr)
   );

   assign rom_oe = port_strobe & (fixed_hit | (|win_hit));

endmodule

// File: rtl/rwm_checker.sv
module rwm_checker #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned ROM_AW     = 19,
   parameter int unsigned PAGE_SHIFT = 11,
   parameter int unsigned NUM_WIN    = 4
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic [ADDR_W-1:0]                     cpu_addr,
   input logic                                  port_strobe,
   input logic [ROM_AW-PAGE_SHIFT-1:0]          rom_addr,
   input logic                                  rom_oe,
   input logic [NUM_WIN*(ROM_AW-PAGE_SHIFT)-1:0] bank_flat
);

   localparam int unsigned OUT_W = ROM_AW - PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] GAP_BASE  = {ADDR_W{1'b1}} << PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] FIXED_END = ADDR_W'(rwm_pkg::fixed_page_limit(ADDR_W - PAGE_SHIFT, NUM_WIN)) << PAGE_SHIFT;

   assert_oe_off_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !port_strobe |-> !rom_oe);

   assert_fixed_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < FIXED_END) |-> (rom_addr == OUT_W'(cpu_addr >> PAGE_SHIFT)) && (rom_oe == port_strobe));

   assert_gap_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= GAP_BASE) |-> (rom_addr == '0) && !rom_oe);

   assert_write_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_flat) |-> ($past(port_strobe) && !$past(port_strobe, 2)));

endmodule

bind rom_window_mapper rwm_checker #(
   .ADDR_W     (ADDR_W),
   .ROM_AW     (ROM_AW),
   .PAGE_SHIFT (PAGE_SHIFT),
   .NUM_WIN    (NUM_WIN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_addr    (cpu_addr),
   .port_strobe (port_strobe),
   .rom_addr    (rom_addr),
   .rom_oe      (rom_oe),
   .bank_flat   (bank_q)
);

// File: tb/sim_rom_window_mapper.sv
`timescale 1ns/1ps
module sim_rom_window_mapper;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] addr;
   logic        strobe;
   logic [7:0]  rom_addr;
   logic        rom_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int shadow [4];

   always #2 clk = ~clk;

   rom_window_mapper u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_addr    (addr),
      .port_strobe (strobe),
      .rom_addr    (rom_addr),
      .rom_oe      (rom_oe)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s addr=%04h actual=%0h expected=%0h", tag, addr, got, exp);
      end
   endtask

   function automatic string tag_of(input int a);
      if (a < 'h8000)  return "R5";
      if (a < 'hC000)  return "R6";
      if (a < 'hE000)  return "R7";
      if (a < 'hF000)  return "R8";
      if (a < 'hF800)  return "R9";
      return "R10";
   endfunction

   // Reference: byte offset = bank * window size + offset in window; ROM page = byte >> 11.
   function automatic int ref_page(input int a);
      int w, base, size, b;
      if (a < 'h8000) return a >> 11;
      if (a >= 'hF800) return 0;
      if (a >= 'hF000)      begin w = 0; base = 'hF000; size = 'h0800; end
      else if (a >= 'hE000) begin w = 1; base = 'hE000; size = 'h1000; end
      else if (a >= 'hC000) begin w = 2; base = 'hC000; size = 'h2000; end
      else                  begin w = 3; base = 'h8000; size = 'h4000; end
      b = shadow[w] % (256 >> w);
      return ((b * size + (a - base)) >> 11) & 'hFF;
   endfunction

   task automatic read_chk(input string tag, input int a);
      addr = a[15:0];
      #0.5;
      chk(tag, int'(rom_addr), ref_page(a));
      chk(tag, int'(rom_oe), (strobe && a < 'hF800) ? 1 : 0);
   endtask

   task automatic write_win(input int w, input int v);
      @(negedge clk);
      strobe = 1'b0;
      addr   = {v[7:0], 6'd0, w[1:0]};
      @(negedge clk);
      strobe = 1'b1;
      @(negedge clk);
      shadow[w] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) shadow[i] = 0;
      // Strobe high with a write pattern across reset release (R3).
      rst_n  = 1'b0;
      strobe = 1'b1;
      addr   = 16'hFF03;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: all windows read bank 0 after reset.
      read_chk("R1", 'h8000);
      read_chk("R1", 'hC000);
      read_chk("R1", 'hE000);
      read_chk("R1", 'hF000);
      // R3: window 3 was not loaded with the pattern present at reset release.
      read_chk("R3", 'hBFFF);

      // R4: output enable off while strobe low.
      @(negedge clk);
      strobe = 1'b0;
      addr   = 16'h8000;
      #0.5 chk("R4", int'(rom_oe), 0);
      addr   = 16'h1234;
      #0.5 chk("R4", int'(rom_oe), 0);
      write_win(3, 0);

      // R5: straight-through region, first and last byte of each page.
      for (int p = 0; p < 16; p++) begin
         read_chk("R5", p * 'h800);
         read_chk("R5", p * 'h800 + 'h7FF);
      end

      // R6: worked example, bank $81 into window 3.
      write_win(3, 'h81);
      read_chk("R6", 'h8000);
      chk("R6", int'(rom_addr), 'h08);
      read_chk("R6", 'hBFFF);
      chk("R6", int'(rom_addr), 'h0F);

      // R12: upper bits above register width dropped.
      write_win(3, 'hE1);
      read_chk("R12", 'h8000);
      chk("R12", int'(rom_addr), 'h08);
      write_win(1, 'hFF);
      read_chk("R12", 'hE000);
      chk("R12", int'(rom_addr), 'hFE);

      // Sweep every value into every window, reading each page boundary (R6..R9, R11, R12, R10).
      for (int w = 0; w < 4; w++) begin
         for (int v = 0; v < 256; v++) begin
            int base, pages;
            write_win(w, v);
            base  = 'h10000 - ('h1000 << w);
            pages = 1 << w;
            for (int p = 0; p < pages; p++) begin
               read_chk(v >= (256 >> w) ? "R12" : tag_of(base), base + p * 'h800);
               read_chk(tag_of(base), base + p * 'h800 + 'h7FF);
            end
            read_chk("R11", 'h8000 + (v % 8) * 'h800);
            read_chk("R11", 'hC000 + (v % 4) * 'h800);
            read_chk("R11", 'hE000 + (v % 2) * 'h800);
            read_chk("R11", 'hF000 + v);
            read_chk("R10", 'hF800 + v * 8);
         end
      end

      // R2: strobe held high while the bus carries a different write pattern.
      write_win(3, 5);
      @(negedge clk);
      addr = 16'h1A03;
      repeat (3) @(negedge clk);
      read_chk("R2", 'h8000);
      chk("R2", int'(rom_addr), 'h28);

      // R2: falling strobe with a decoy pattern, then a legal write to window 2.
      @(negedge clk);
      strobe = 1'b0;
      addr   = 16'h1B03;
      repeat (2) @(negedge clk);
      addr = 16'h0702;
      @(negedge clk);
      strobe = 1'b1;
      @(negedge clk);
      shadow[2] = 7;
      read_chk("R2", 'h8000);
      chk("R2", int'(rom_addr), 'h28);
      read_chk("R11", 'hC000);
      chk("R11", int'(rom_addr), 'h1C);

      // R10: top page of the CPU space stays quiet.
      read_chk("R10", 'hF800);
      read_chk("R10", 'hFFFF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule